// File: doc/BRIEF.md
# Source-Throttling Fairness Controller

This block keeps several cores that share a memory system from slowing one another unevenly. Every cycle it is told which cores suffered interference and, for each of them, which other core caused it. From these bits it builds a per-core excess-cycle count and a core-by-core interference table. At the end of each fixed-length interval it estimates every core's slowdown from the shared-mode cycle count supplied for that core, and forms the ratio of the largest slowdown to the smallest.

When that ratio is above a programmable target, the core that did the most damage to the slowest core is stepped down one throttle level, and the slowest core is stepped up one level. Each level gives an outstanding-miss quota and an injection period. A per-core gate then raises a one-cycle enable once every period cycles, and it stays high at the full level. The ratio test uses cross-multiplication, so no divider is needed.

Top module: `thr_fair_ctrl`

## Requirements
- R1: After reset every core is at level 0: `miss_quota` is 128 and `inj_en` is high in every cycle.
- R2: Decisions are taken only on the last cycle of each window of `INTERVAL_LEN` cycles counted from reset release. Quotas are constant at all other times. Interference presented in that last cycle is not counted, and all counts clear there, so each window is judged on its own.
- R3: A core's excess count rises by one for each cycle its `intf_hit` bit is set. Its alone time is shared cycles minus excess, or 1 if that result would not be positive. Its slowdown is shared cycles divided by alone time.
- R4: Throttling happens only when max slowdown / min slowdown is strictly greater than `unfair_tgt`. The target is unsigned fixed point with `TGT_FRAC` fraction bits; with 8 fraction bits, 358 stands for about 1.4.
- R5: The slowest core moves up one level, toward level 0. When slowdowns tie, the lowest core index counts as slowest, and also as fastest.
- R6: `intf_src[i]` is the binary index of the core that interfered with core i. The core with the largest count against the slowest core moves down one level, with ties going to the lowest index. If no other core has a nonzero count against the slowest core, no core moves down.
- R7: Levels 0..7 give quota / injection period of 128/1, 64/2, 32/4, 12/10, 6/20, 5/25, 3/30 and 2/50.
- R8: Levels saturate: a core at level 0 stays at 0 when moved up, and a core at level 7 stays at 7 when moved down.
- R9: Outside level 0, `inj_en[i]` pulses for one cycle once every period cycles of the core's current level.
- R10: A source index equal to the interfered core's own index adds to that core's excess count but to no pair count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| intf_hit | input | N_CORES | Per-core interference bit for this cycle |
| intf_src | input | N_CORES x IDW | Interfering core index for each core |
| shared_cyc | input | N_CORES x CNT_W | Shared-mode cycle count per core, sampled at the window end |
| unfair_tgt | input | TGT_W | Unfairness target, fixed point |
| miss_quota | output | N_CORES x 8 | Outstanding-miss quota per core |
| inj_en | output | N_CORES | Per-core injection enable |

## Verification
A wrong count or a bad table entry stays hidden until the next window end. It then shows up at once as a quota step on the wrong core, a missing step, or a step in the wrong direction. A stale count that survives a window end skews the following decision, which is why back-to-back windows that fall below the target only when cleared separately are used. A level that is wrong, or a gate counter that misses its reload, shows within one injection period as an enable pulse spacing that does not match the quota at the port.

// File: rtl/thr_pkg.sv
package thr_pkg;

   localparam int unsigned LVL_N   = 8;
   localparam int unsigned LVL_W   = 3;
   localparam int unsigned QUOTA_W = 8;
   localparam int unsigned PER_W   = 6;

   typedef logic [LVL_W-1:0]   lvl_t;
   typedef logic [QUOTA_W-1:0] quota_t;
   typedef logic [PER_W-1:0]   period_t;

   localparam lvl_t LVL_FULL = lvl_t'(0);
   localparam lvl_t LVL_MIN  = lvl_t'(LVL_N - 1);

   // outstanding-miss quota granted at each throttle level
   function automatic quota_t lvl_quota(input lvl_t l);
      case (l)
         3'd0:    lvl_quota = quota_t'(128);
         3'd1:    lvl_quota = quota_t'(64);
         3'd2:    lvl_quota = quota_t'(32);
         3'd3:    lvl_quota = quota_t'(12);
         3'd4:    lvl_quota = quota_t'(6);
         3'd5:    lvl_quota = quota_t'(5);
         3'd6:    lvl_quota = quota_t'(3);
         default: lvl_quota = quota_t'(2);
      endcase
   endfunction

   // cycles between injection opportunities at each level
   function automatic period_t lvl_period(input lvl_t l);
      case (l)
         3'd0:    lvl_period = period_t'(1);
         3'd1:    lvl_period = period_t'(2);
         3'd2:    lvl_period = period_t'(4);
         3'd3:    lvl_period = period_t'(10);
         3'd4:    lvl_period = period_t'(20);
         3'd5:    lvl_period = period_t'(25);
         3'd6:    lvl_period = period_t'(30);
         default: lvl_period = period_t'(50);
      endcase
   endfunction

endpackage

// File: rtl/thr_intf_track.sv
module thr_intf_track #(
   parameter int unsigned N_CORES = 4,
   parameter int unsigned CNT_W   = 16,
   parameter bit          SAT_CNT = 1'b1,
   localparam int unsigned IDW    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 clr,
   input  logic [N_CORES-1:0]                   hit,
   input  logic [N_CORES-1:0][IDW-1:0]          src,
   output logic [N_CORES-1:0][CNT_W-1:0]        excess,
   output logic [N_CORES-1:0][N_CORES-1:0][CNT_W-1:0] pair
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // step a counter by one, saturating or wrapping as chosen
   function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
      if (SAT_CNT && (v == CNT_MAX)) bump = v;
      else                           bump = v + 1'b1;
   endfunction

   for (genvar i = 0; i < N_CORES; i++) begin : g_core
      logic [CNT_W-1:0] exc_q;

      always_ff @(posedge clk) begin
         if (!rst_n)      exc_q <= '0;
         else if (clr)    exc_q <= '0;
         else if (hit[i]) exc_q <= bump(exc_q);
      end
      assign excess[i] = exc_q;

      for (genvar j = 0; j < N_CORES; j++) begin : g_pair
         if (i == j) begin : g_diag
            assign pair[i][j] = '0;
         end else begin : g_off
            logic [CNT_W-1:0] pc_q;
            always_ff @(posedge clk) begin
               if (!rst_n)   pc_q <= '0;
               else if (clr) pc_q <= '0;
               else if (hit[i] && (src[i] == IDW'(j))) pc_q <= bump(pc_q);
            end
            assign pair[i][j] = pc_q;
         end
      end
   end

endmodule

// File: rtl/thr_unfair_eval.sv
module thr_unfair_eval #(
   parameter int unsigned N_CORES  = 4,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned TGT_W    = 16,
   parameter int unsigned TGT_FRAC = 8,
   localparam int unsigned IDW     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic [N_CORES-1:0][CNT_W-1:0]              shared,
   input  logic [N_CORES-1:0][CNT_W-1:0]              excess,
   input  logic [N_CORES-1:0][N_CORES-1:0][CNT_W-1:0] pair,
   input  logic [TGT_W-1:0]                           tgt,
   output logic [IDW-1:0]                             slow_id,
   output logic [IDW-1:0]                             intf_id,
   output logic                                       intf_vld,
   output logic                                       exceed
);

   localparam int unsigned PW = 2 * CNT_W;
   localparam int unsigned EW = PW + TGT_W;

   logic [N_CORES-1:0][CNT_W-1:0] alone;

   for (genvar i = 0; i < N_CORES; i++) begin : g_alone
      assign alone[i] = (shared[i] > excess[i]) ? (shared[i] - excess[i])
                                                : CNT_W'(1);
   end

   function automatic logic [PW-1:0] wmul(input logic [CNT_W-1:0] a,
                                          input logic [CNT_W-1:0] b);
      wmul = PW'(a) * PW'(b);
   endfunction

   logic [IDW-1:0] s_id, f_id;

   // slowest / fastest search by cross-multiplied slowdown ratios
   always_comb begin
      s_id = '0;
      f_id = '0;
      for (int i = 1; i < N_CORES; i++) begin
         if (wmul(shared[i], alone[s_id]) > wmul(shared[s_id], alone[i]))
            s_id = IDW'(i);
         if (wmul(shared[i], alone[f_id]) < wmul(shared[f_id], alone[i]))
            f_id = IDW'(i);
      end
   end

   logic [EW-1:0] lhs, rhs;
   assign lhs    = EW'(wmul(shared[s_id], alone[f_id])) << TGT_FRAC;
   assign rhs    = EW'(tgt) * EW'(wmul(alone[s_id], shared[f_id]));
   assign exceed = lhs > rhs;

   // heaviest interferer against the slowest core
   always_comb begin
      logic [CNT_W-1:0] best;
      best     = '0;
      intf_id  = '0;
      intf_vld = 1'b0;
      for (int j = 0; j < N_CORES; j++) begin
         if ((IDW'(j) != s_id) && (pair[s_id][j] > best)) begin
            best     = pair[s_id][j];
            intf_id  = IDW'(j);
            intf_vld = 1'b1;
         end
      end
   end

   assign slow_id = s_id;

endmodule

// File: rtl/thr_level_ctrl.sv
module thr_level_ctrl
   import thr_pkg::*;
#(
   parameter int unsigned N_CORES = 4,
   localparam int unsigned IDW    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       apply,
   input  logic [IDW-1:0]             slow_id,
   input  logic [IDW-1:0]             intf_id,
   input  logic                       intf_vld,
   output logic [N_CORES-1:0][QUOTA_W-1:0] quota,
   output logic [N_CORES-1:0]         inj
);

   for (genvar i = 0; i < N_CORES; i++) begin : g_core
      lvl_t    lvl_q;
      period_t cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lvl_q <= LVL_FULL;
         end else if (apply) begin
            if (slow_id == IDW'(i)) begin
               if (lvl_q != LVL_FULL) lvl_q <= lvl_q - 1'b1;
            end else if (intf_vld && (intf_id == IDW'(i))) begin
               if (lvl_q != LVL_MIN) lvl_q <= lvl_q + 1'b1;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if ((lvl_q == LVL_FULL) || (cnt_q == '0))
            cnt_q <= lvl_period(lvl_q) - 1'b1;
         else
            cnt_q <= cnt_q - 1'b1;
      end

      assign quota[i] = lvl_quota(lvl_q);
      assign inj[i]   = (lvl_q == LVL_FULL) || (cnt_q == '0);
   end

endmodule

// File: rtl/thr_fair_ctrl.sv
module thr_fair_ctrl
   import thr_pkg::*;
#(
   parameter int unsigned N_CORES      = 4,
   parameter int unsigned INTERVAL_LEN = 8192,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned TGT_W        = 16,
   parameter int unsigned TGT_FRAC     = 8,
   parameter bit          SAT_CNT      = 1'b1,
   localparam int unsigned IDW         = (N_CORES > 1) ? $clog2(N_CORES) : 1,
   localparam int unsigned IC_W        = $clog2(INTERVAL_LEN)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [N_CORES-1:0]                 intf_hit,
   input  logic [N_CORES-1:0][IDW-1:0]        intf_src,
   input  logic [N_CORES-1:0][CNT_W-1:0]      shared_cyc,
   input  logic [TGT_W-1:0]                   unfair_tgt,
   output logic [N_CORES-1:0][QUOTA_W-1:0]    miss_quota,
   output logic [N_CORES-1:0]                 inj_en
);

   if (N_CORES < 2) begin : g_bad_cores
      $error("thr_fair_ctrl: N_CORES must be at least 2");
   end
   if (INTERVAL_LEN < 4) begin : g_bad_len
      $error("thr_fair_ctrl: INTERVAL_LEN must be at least 4");
   end
   if (TGT_FRAC >= TGT_W) begin : g_bad_frac
      $error("thr_fair_ctrl: TGT_FRAC must be below TGT_W");
   end
   if ((1 << CNT_W) <= INTERVAL_LEN) begin : g_bad_cnt
      $error("thr_fair_ctrl: CNT_W too narrow for INTERVAL_LEN");
   end

   logic [IC_W-1:0] ic_q;
   logic            at_end;

   assign at_end = (ic_q == IC_W'(INTERVAL_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      ic_q <= '0;
      else if (at_end) ic_q <= '0;
      else             ic_q <= ic_q + 1'b1;
   end

   logic [N_CORES-1:0][CNT_W-1:0]              excess_q;
   logic [N_CORES-1:0][N_CORES-1:0][CNT_W-1:0] pair_q;
   logic [IDW-1:0] slow_id, intf_id;
   logic           intf_vld, exceed;

   thr_intf_track #(
      .N_CORES (N_CORES),
      .CNT_W   (CNT_W),
      .SAT_CNT (SAT_CNT)
   ) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (at_end),
      .hit    (intf_hit),
      .src    (intf_src),
      .excess (excess_q),
      .pair   (pair_q)
   );

   thr_unfair_eval #(
      .N_CORES  (N_CORES),
      .CNT_W    (CNT_W),
      .TGT_W    (TGT_W),
      .TGT_FRAC (TGT_FRAC)
   ) u_eval (
      .shared   (shared_cyc),
      .excess   (excess_q),
      .pair     (pair_q),
      .tgt      (unfair_tgt),
      .slow_id  (slow_id),
      .intf_id  (intf_id),
      .intf_vld (intf_vld),
      .exceed   (exceed)
   );

   thr_level_ctrl #(
      .N_CORES (N_CORES)
   ) u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .apply    (at_end && exceed),
      .slow_id  (slow_id),
      .intf_id  (intf_id),
      .intf_vld (intf_vld),
      .quota    (miss_quota),
      .inj      (inj_en)
   );

endmodule

// File: rtl/thr_fair_ctrl_chk.sv
module thr_fair_ctrl_chk
   import thr_pkg::*;
#(
   parameter int unsigned N_CORES      = 4,
   parameter int unsigned INTERVAL_LEN = 8192,
   parameter int unsigned CNT_W        = 16
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [N_CORES-1:0][QUOTA_W-1:0] miss_quota,
   input logic [N_CORES-1:0]              inj_en,
   input logic [N_CORES-1:0][CNT_W-1:0]   excess
);

   logic [31:0] ic;
   always_ff @(posedge clk) begin
      if (!rst_n)                          ic <= '0;
      else if (ic == 32'(INTERVAL_LEN - 1)) ic <= '0;
      else                                 ic <= ic + 1'b1;
   end

   logic [N_CORES-1:0][QUOTA_W-1:0] prev_q;
   logic [N_CORES-1:0]              chg;
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= {N_CORES{QUOTA_W'(128)}};
      else        prev_q <= miss_quota;
   end
   always_comb begin
      for (int i = 0; i < N_CORES; i++) chg[i] = miss_quota[i] != prev_q[i];
   end

   function automatic logic is_legal(input logic [QUOTA_W-1:0] q);
      is_legal = 1'b0;
      for (int l = 0; l < LVL_N; l++)
         if (q == lvl_quota(lvl_t'(l))) is_legal = 1'b1;
   endfunction

   // R2: quotas only move right after a window end
   p_quota_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ic != 0) |-> (chg == '0));

   // R2: counts are empty at the start of every window
   p_count_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ic == 0) |-> (excess == '0));

   // R5 / R6: one decision moves at most two cores
   p_two_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chg) <= 2);

   for (genvar i = 0; i < N_CORES; i++) begin : g_core
      // R7: quota is always a table value
      p_quota_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
         is_legal(miss_quota[i]));

      // R1 / R9: full level injects every cycle
      p_full_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (miss_quota[i] == QUOTA_W'(128)) |-> inj_en[i]);

      // R9: a throttled core never injects two cycles running
      p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (inj_en[i] && (miss_quota[i] != QUOTA_W'(128))) |=> !inj_en[i]);
   end

endmodule

bind thr_fair_ctrl thr_fair_ctrl_chk #(
   .N_CORES      (N_CORES),
   .INTERVAL_LEN (INTERVAL_LEN),
   .CNT_W        (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .miss_quota (miss_quota),
   .inj_en     (inj_en),
   .excess     (excess_q)
);

// File: tb/thr_fair_ctrl_tb_top.sv
module thr_fair_ctrl_tb_top;

   localparam int NC  = 4;
   localparam int LEN = 64;
   localparam int CW  = 16;
   localparam int TW  = 16;
   localparam int NV  = 13;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NC-1:0]        intf_hit = '0;
   logic [NC-1:0][1:0]   intf_src = '0;
   logic [NC-1:0][CW-1:0] shared_cyc;
   logic [TW-1:0]        unfair_tgt = 16'd358;
   logic [NC-1:0][7:0]   miss_quota;
   logic [NC-1:0]        inj_en;

   always #5 clk = ~clk;

   initial for (int k = 0; k < NC; k++) shared_cyc[k] = 16'd100;

   thr_fair_ctrl #(
      .N_CORES (NC), .INTERVAL_LEN (LEN), .CNT_W (CW),
      .TGT_W (TW), .TGT_FRAC (8), .SAT_CNT (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .intf_hit (intf_hit), .intf_src (intf_src),
      .shared_cyc (shared_cyc), .unfair_tgt (unfair_tgt),
      .miss_quota (miss_quota), .inj_en (inj_en)
   );

   typedef struct packed {
      logic [3:0][5:0] ex;   // interfered cycles per core {c3,c2,c1,c0}
      logic [3:0][1:0] sr;   // source index per core
      logic [3:0][2:0] lv;   // expected level per core after the window
   } vec_t;

   localparam vec_t VT [NV] = '{
      '{ex:{6'd0,6'd0,6'd0,6'd40},   sr:{2'd0,2'd0,2'd0,2'd2}, lv:{3'd0,3'd1,3'd0,3'd0}}, // R3 R4 R6
      '{ex:{6'd10,6'd0,6'd0,6'd0},   sr:{2'd1,2'd0,2'd0,2'd0}, lv:{3'd0,3'd1,3'd0,3'd0}}, // R4 below target
      '{ex:{6'd0,6'd0,6'd50,6'd0},   sr:{2'd0,2'd0,2'd2,2'd0}, lv:{3'd0,3'd2,3'd0,3'd0}}, // R6 R8 up-sat
      '{ex:{6'd0,6'd45,6'd0,6'd0},   sr:{2'd0,2'd0,2'd0,2'd0}, lv:{3'd0,3'd1,3'd0,3'd1}}, // R5 up
      '{ex:{6'd0,6'd0,6'd0,6'd20},   sr:{2'd0,2'd0,2'd0,2'd1}, lv:{3'd0,3'd1,3'd0,3'd1}}, // R2 first half
      '{ex:{6'd0,6'd0,6'd0,6'd20},   sr:{2'd0,2'd0,2'd0,2'd1}, lv:{3'd0,3'd1,3'd0,3'd1}}, // R2 counts cleared
      '{ex:{6'd0,6'd0,6'd0,6'd28},   sr:{2'd0,2'd0,2'd0,2'd3}, lv:{3'd0,3'd1,3'd0,3'd1}}, // R4 just under
      '{ex:{6'd0,6'd0,6'd0,6'd29},   sr:{2'd0,2'd0,2'd0,2'd3}, lv:{3'd1,3'd1,3'd0,3'd0}}, // R4 just over
      '{ex:{6'd60,6'd0,6'd0,6'd0},   sr:{2'd0,2'd0,2'd0,2'd0}, lv:{3'd0,3'd1,3'd0,3'd1}}, // R5 R6
      '{ex:{6'd0,6'd0,6'd50,6'd30},  sr:{2'd0,2'd0,2'd3,2'd3}, lv:{3'd1,3'd1,3'd0,3'd1}}, // R3 two victims
      '{ex:{6'd0,6'd0,6'd0,6'd40},   sr:{2'd0,2'd0,2'd0,2'd0}, lv:{3'd1,3'd1,3'd0,3'd0}}, // R10 self source
      '{ex:{6'd0,6'd0,6'd40,6'd40},  sr:{2'd0,2'd0,2'd2,2'd1}, lv:{3'd1,3'd1,3'd1,3'd0}}, // R5 tie
      '{ex:{6'd40,6'd40,6'd40,6'd40},sr:{2'd0,2'd3,2'd2,2'd1}, lv:{3'd1,3'd1,3'd1,3'd0}}  // R4 balanced
   };

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // quota per level, from R7
   function automatic int exp_quota(input int lv);
      case (lv)
         0: exp_quota = 128;  1: exp_quota = 64;  2: exp_quota = 32;
         3: exp_quota = 12;   4: exp_quota = 6;   5: exp_quota = 5;
         6: exp_quota = 3;    default: exp_quota = 2;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_lv(input string tag, input logic [3:0][2:0] lv);
      for (int k = 0; k < NC; k++)
         chk($sformatf("%s core%0d quota", tag, k), int'(miss_quota[k]), exp_quota(int'(lv[k])));
   endtask

   task automatic run_window(input logic [3:0][5:0] ex, input logic [3:0][1:0] sr);
      for (int c = 0; c < LEN; c++) begin
         for (int k = 0; k < NC; k++) begin
            intf_hit[k] = (c < int'(ex[k]));
            intf_src[k] = sr[k];
         end
         @(posedge clk);
         @(negedge clk);
      end
      intf_hit = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      intf_hit = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired act=running exp=finished");
         finish_run();
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      for (int k = 0; k < NC; k++) begin
         chk($sformatf("R1 reset core%0d quota", k), int'(miss_quota[k]), 128);
         chk($sformatf("R1 reset core%0d inj", k), int'(inj_en[k]), 1);
      end

      // table walk: R2 R3 R4 R5 R6 R7 R8 R10
      for (int v = 0; v < NV; v++) begin
         run_window(VT[v].ex, VT[v].sr);
         chk_lv($sformatf("R2-R10 vector %0d", v), VT[v].lv);
      end

      // R6: two sources against core0 in one window, larger one throttled
      for (int c = 0; c < LEN; c++) begin
         intf_hit    = '0;
         intf_hit[0] = (c < 45);
         intf_src[0] = (c < 20) ? 2'd1 : 2'd3;
         @(posedge clk);
         @(negedge clk);
      end
      intf_hit = '0;
      chk_lv("R6 argmax", {3'd2, 3'd1, 3'd1, 3'd0});

      // R1: reset returns all cores to full level
      do_reset();
      chk_lv("R1 re-reset", {3'd0, 3'd0, 3'd0, 3'd0});

      // R8: core0 pushed down past the last level
      for (int w = 0; w < 8; w++) begin
         run_window({6'd0, 6'd0, 6'd60, 6'd0}, {2'd0, 2'd0, 2'd0, 2'd0});
         if (w == 6) chk_lv("R8 reach min", {3'd0, 3'd0, 3'd0, 3'd7});
      end
      chk_lv("R8 saturate min", {3'd0, 3'd0, 3'd0, 3'd7});

      // R9: injection pulse spacing over two quiet windows
      begin
         int first, second, cnt1;
         first = -1; second = -1; cnt1 = 0;
         for (int c = 0; c < 2 * LEN; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (inj_en[0]) begin
               if (first < 0) first = c;
               else if (second < 0) second = c;
            end
            if (inj_en[1]) cnt1++;
         end
         chk("R9 core0 pulse seen", (first >= 0 && second >= 0) ? 1 : 0, 1);
         chk("R9 core0 gap", second - first, 50);
         chk("R9 core1 full rate pulses", cnt1, 2 * LEN);
         chk_lv("R2 quiet windows", {3'd0, 3'd0, 3'd0, 3'd7});
      end

      done = 1'b1;
      finish_run();
   end

endmodule